// File: doc/BRIEF.md
# Idle-Mode Entry and Wake Sequencer

This block sequences a processor core through its idle instruction. When the decoder presents the idle opcode, the sequencer asks the pipeline to flush. It then waits for every outstanding memory cycle to finish and raises an idle status flag. Next it waits for the instruction buffer to fill. Only then does it withdraw the core clock enable and raise the idle output pin.

The sequencer runs on the free-running input clock, so it keeps watching interrupts while the core is stopped. It wakes on any pending maskable source whose per-source enable bit is set, or on the nonmaskable line. The global interrupt mask plays no part in waking. On wake it clears the flag, restores the core clock, drops the idle pin and issues a one-cycle program-counter advance. It also decides whether to request service-routine dispatch. A nonmaskable wake always requests dispatch. A maskable wake requests dispatch only when the global mask is clear. An interrupt that shows up while entry is still in progress is held, so the core leaves idle one cycle after reaching it.

Top module: `idle_mode_ctrl`

## Requirements
- R1: Entry starts only when `op_valid` is 1 and `op_code` equals 16'h7621 while the core is running. Any other code, or the right code with `op_valid` at 0, leaves `flush_req` at 0 and `core_clk_en` at 1.
- R2: `flush_req` is 1 from the cycle after the idle opcode is accepted until the cycle after `pipe_empty` is seen as 1. `idle_flag` stays 0 throughout this phase.
- R3: After the flush, the sequencer waits while `mem_busy` is 1. `idle_flag` becomes 1 in the cycle after `mem_busy` is seen as 0, and not before.
- R4: `core_clk_en` falls to 0 and `idle_out` rises to 1 in the cycle after `ibuf_full` is seen as 1 with `idle_flag` already set. While the sequencer waits for the buffer, `core_clk_en` stays 1.
- R5: While idle with no wake source, `core_clk_en` stays 0, `idle_out` stays 1, `idle_flag` stays 1 and `pc_inc` stays 0.
- R6: The wake condition is any bit set in both `irq_pend` and `irq_en`, or `nmi` at 1. `gmask` has no effect on waking. A pending bit whose enable bit is 0 does not wake.
- R7: In the cycle after the wake condition is seen while idle, `core_clk_en` is 1, `idle_out` is 0 and `idle_flag` is 0. In that same cycle `pc_inc` is 1, and it is 1 for exactly that one cycle.
- R8: On a wake caused only by maskable sources, `isr_req` pulses with `pc_inc` when `gmask` is 0 and stays 0 when `gmask` is 1.
- R9: On a wake in which `nmi` is a source, `isr_req` pulses with `pc_inc` whatever the value of `gmask`.
- R10: A wake source seen during the flush, drain or buffer-fill phases is held. The sequencer then leaves idle in the cycle after it entered idle, even if the source has gone away. A held nonmaskable source still counts as nonmaskable.
- R11: After reset, `core_clk_en` is 1 and `flush_req`, `idle_out`, `idle_flag`, `pc_inc` and `isr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Decoded opcode is valid |
| op_code | input | 16 | Decoded opcode value |
| pipe_empty | input | 1 | Pipeline has drained |
| mem_busy | input | 1 | Memory cycles are outstanding |
| ibuf_full | input | 1 | Instruction buffer is full |
| irq_pend | input | NUM_IRQ | Pending maskable interrupts |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| nmi | input | 1 | Nonmaskable interrupt line |
| gmask | input | 1 | Global interrupt mask bit |
| flush_req | output | 1 | Pipeline flush request |
| core_clk_en | output | 1 | Core clock enable |
| idle_out | output | 1 | Idle pin |
| idle_flag | output | 1 | Idle status flag |
| pc_inc | output | 1 | One-cycle program-counter advance |
| isr_req | output | 1 | Service-routine dispatch request |

## Verification
The bench drives pending sources that are not enabled while the global mask is clear. A design that woke on pending alone would leave idle there. It also wakes with the global mask set, where a design that folded the mask into the wake test would stay asleep. It stalls each entry phase in turn to catch a flag raised before memory drains, or a clock stopped before the buffer is full. A nonmaskable pulse that comes and goes during the flush checks the held wake: a design without it sleeps forever, and one that lost the source kind would not request dispatch.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;

    localparam int OPC_W = 16;
    localparam logic [OPC_W-1:0] IDLE_OPCODE = 16'h7621;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_FLUSH = 3'd1,
        ST_DRAIN = 3'd2,
        ST_FILL  = 3'd3,
        ST_SLEEP = 3'd4
    } idle_state_t;

    function automatic logic is_idle_op(input logic valid, input logic [OPC_W-1:0] code);
        return valid && (code == IDLE_OPCODE);
    endfunction

endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               armed,
    input  logic               sleeping,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               nmi,
    output logic               wake_now,
    output logic               wake_nmi
);
    logic live_mask;
    logic live_any;
    logic held_any;
    logic held_nmi;

    assign live_mask = |(irq_pend & irq_en);
    assign live_any  = live_mask || nmi;
    assign wake_now  = sleeping && (live_any || held_any);
    assign wake_nmi  = nmi || held_nmi;

    always_ff @(posedge clk) begin
        if (rst || wake_now) begin
            held_any <= 1'b0;
            held_nmi <= 1'b0;
        end else if (armed) begin
            if (live_any) held_any <= 1'b1;
            if (nmi)      held_nmi <= 1'b1;
        end
    end

    AST_HELD_NMI_IMPLIES_ANY: assert property (@(posedge clk) disable iff (rst)
        held_nmi |-> held_any); // R10

    AST_HELD_ONLY_FROM_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(held_any) |-> $past(live_any && armed)); // R10

endmodule

// File: rtl/idle_entry_fsm.sv
module idle_entry_fsm
    import idle_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_hit,
    input  logic pipe_empty,
    input  logic mem_busy,
    input  logic ibuf_full,
    input  logic wake_now,
    input  logic wake_nmi,
    input  logic gmask,
    output logic armed,
    output logic sleeping,
    output logic flush_req,
    output logic core_clk_en,
    output logic idle_out,
    output logic idle_flag,
    output logic pc_inc,
    output logic isr_req
);
    idle_state_t state_q;
    idle_state_t state_d;
    logic        flag_q;
    logic        pc_q;
    logic        isr_q;
    logic        leave;

    assign leave = (state_q == ST_SLEEP) && wake_now;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:   if (op_hit)     state_d = ST_FLUSH;
            ST_FLUSH: if (pipe_empty) state_d = ST_DRAIN;
            ST_DRAIN: if (!mem_busy)  state_d = ST_FILL;
            ST_FILL:  if (ibuf_full)  state_d = ST_SLEEP;
            ST_SLEEP: if (wake_now)   state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            flag_q  <= 1'b0;
            pc_q    <= 1'b0;
            isr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DRAIN && !mem_busy) flag_q <= 1'b1;
            else if (leave)                       flag_q <= 1'b0;
            pc_q  <= leave;
            isr_q <= leave && (wake_nmi || !gmask);
        end
    end

    assign armed       = (state_q == ST_FLUSH) || (state_q == ST_DRAIN) || (state_q == ST_FILL);
    assign sleeping    = (state_q == ST_SLEEP);
    assign flush_req   = (state_q == ST_FLUSH);
    assign core_clk_en = (state_q != ST_SLEEP);
    assign idle_out    = (state_q == ST_SLEEP);
    assign idle_flag   = flag_q;
    assign pc_inc      = pc_q;
    assign isr_req     = isr_q;

    AST_FLAG_BEFORE_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(idle_flag)); // R4

    AST_STOP_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(ibuf_full)); // R4

    AST_FLAG_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(!mem_busy && !flush_req)); // R3

    AST_NO_FLAG_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !idle_flag); // R2

    AST_PC_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(core_clk_en) |-> (pc_inc && !idle_flag)); // R7

    AST_PC_PULSE: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> !pc_inc); // R7

    AST_NO_PC_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en |-> !pc_inc); // R5

    AST_ISR_WITH_PC: assert property (@(posedge clk) disable iff (rst)
        isr_req |-> pc_inc); // R8

endmodule

// File: rtl/idle_mode_ctrl.sv
module idle_mode_ctrl
    import idle_ctl_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [OPC_W-1:0]   op_code,
    input  logic               pipe_empty,
    input  logic               mem_busy,
    input  logic               ibuf_full,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               nmi,
    input  logic               gmask,
    output logic               flush_req,
    output logic               core_clk_en,
    output logic               idle_out,
    output logic               idle_flag,
    output logic               pc_inc,
    output logic               isr_req
);
    logic op_hit;
    logic armed;
    logic sleeping;
    logic wake_now;
    logic wake_nmi;

    assign op_hit = is_idle_op(op_valid, op_code);

    idle_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .sleeping (sleeping),
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .nmi      (nmi),
        .wake_now (wake_now),
        .wake_nmi (wake_nmi)
    );

    idle_entry_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .op_hit      (op_hit),
        .pipe_empty  (pipe_empty),
        .mem_busy    (mem_busy),
        .ibuf_full   (ibuf_full),
        .wake_now    (wake_now),
        .wake_nmi    (wake_nmi),
        .gmask       (gmask),
        .armed       (armed),
        .sleeping    (sleeping),
        .flush_req   (flush_req),
        .core_clk_en (core_clk_en),
        .idle_out    (idle_out),
        .idle_flag   (idle_flag),
        .pc_inc      (pc_inc),
        .isr_req     (isr_req)
    );

    AST_ENTRY_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_req) |-> $past(op_hit)); // R1

endmodule

// File: tb/idle_mode_ctrl_bench.sv
module idle_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 16;
    localparam int NVEC = 6;

    logic clk = 1'b0;
    logic rst;
    logic op_valid;
    logic [15:0] op_code;
    logic pipe_empty, mem_busy, ibuf_full;
    logic [NI-1:0] irq_pend, irq_en;
    logic nmi, gmask;
    logic flush_req, core_clk_en, idle_out, idle_flag, pc_inc, isr_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_mode_ctrl #(.NUM_IRQ(NI)) u_idle_mode_ctrl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .pipe_empty(pipe_empty), .mem_busy(mem_busy), .ibuf_full(ibuf_full),
        .irq_pend(irq_pend), .irq_en(irq_en), .nmi(nmi), .gmask(gmask),
        .flush_req(flush_req), .core_clk_en(core_clk_en), .idle_out(idle_out),
        .idle_flag(idle_flag), .pc_inc(pc_inc), .isr_req(isr_req)
    );

    // {pend, en, nmi, gmask, expect_wake, expect_isr}
    localparam logic [35:0] VEC [NVEC] = '{
        {16'h0001, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1},
        {16'h0001, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0},
        {16'h8000, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
        {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1},
        {16'h0100, 16'hFF00, 1'b1, 1'b0, 1'b1, 1'b1},
        {16'h00F0, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        op_valid = 0; op_code = 16'h0000;
        irq_pend = '0; irq_en = '0; nmi = 0; gmask = 0;
    endtask

    task automatic issue_idle();
        op_valid = 1; op_code = 16'h7621;
        tick();
        op_valid = 0; op_code = 16'h0000;
    endtask

    task automatic enter_fast();
        pipe_empty = 1; mem_busy = 0; ibuf_full = 1;
        issue_idle();
        tick(); tick(); tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; quiet();
        pipe_empty = 1; mem_busy = 0; ibuf_full = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 clk_en", core_clk_en, 1);
        chk("R11 flush", flush_req, 0);
        chk("R11 idle", idle_out, 0);
        chk("R11 flag", idle_flag, 0);
        chk("R11 pc_inc", pc_inc, 0);
        chk("R11 isr", isr_req, 0);

        // Vector table walk: R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [35:0] v;
            v = VEC[i];
            enter_fast();
            chk("R4 asleep", idle_out, 1);
            irq_pend = v[35:20]; irq_en = v[19:4]; nmi = v[3]; gmask = v[2];
            tick();
            chk("R6 wake", pc_inc, v[1]);
            chk("R7 idle_out", idle_out, !v[1]);
            chk("R7 flag", idle_flag, !v[1]);
            chk(v[3] ? "R9 isr" : "R8 isr", isr_req, v[0]);
            quiet();
            if (!v[1]) begin
                nmi = 1;
                tick();
                nmi = 0;
                chk("R9 nmi exit", pc_inc, 1);
            end
            tick();
            chk("R7 pulse end", pc_inc, 0);
            chk("R7 running", core_clk_en, 1);
        end

        // R1: wrong opcode, and right opcode without valid
        op_valid = 1; op_code = 16'h7620;
        tick();
        chk("R1 wrong code", flush_req, 0);
        op_valid = 0; op_code = 16'h7621;
        tick();
        chk("R1 not valid", flush_req, 0);
        tick();
        chk("R1 still running", core_clk_en, 1);
        quiet();

        // R2 R3 R4 R5: stall each phase
        pipe_empty = 0; mem_busy = 1; ibuf_full = 0;
        issue_idle();
        chk("R2 flush on", flush_req, 1);
        tick(); tick();
        chk("R2 flush held", flush_req, 1);
        chk("R2 no flag", idle_flag, 0);
        pipe_empty = 1;
        tick();
        chk("R2 flush off", flush_req, 0);
        tick(); tick();
        chk("R3 no flag while busy", idle_flag, 0);
        mem_busy = 0;
        tick();
        chk("R3 flag set", idle_flag, 1);
        tick(); tick();
        chk("R4 clk held", core_clk_en, 1);
        ibuf_full = 1;
        tick();
        chk("R4 clk stop", core_clk_en, 0);
        chk("R4 idle pin", idle_out, 1);
        irq_pend = 16'h0010; irq_en = 16'h0000;
        tick(); tick(); tick();
        chk("R5 stay idle", idle_out, 1);
        chk("R5 no pc", pc_inc, 0);
        chk("R5 flag held", idle_flag, 1);
        irq_en = 16'h0010; gmask = 1;
        tick();
        chk("R6 mask ignored", pc_inc, 1);
        chk("R8 masked no isr", isr_req, 0);
        quiet();
        tick();

        // R10: nmi pulse during flush, held until idle
        pipe_empty = 0; mem_busy = 0; ibuf_full = 1;
        issue_idle();
        nmi = 1; gmask = 1;
        tick();
        nmi = 0;
        pipe_empty = 1;
        tick(); tick(); tick();
        chk("R10 reached idle", idle_out, 1);
        tick();
        chk("R10 wake", pc_inc, 1);
        chk("R10 clk back", core_clk_en, 1);
        chk("R10 nmi kept", isr_req, 1);
        quiet();
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule